// File: doc/BRIEF.md
# Call, Return and Interrupt Sequencer

This block owns the program counter, the stack pointer and the status word of a small processor, and changes them whenever control flow leaves the straight line. It handles four operations: subroutine call, subroutine return, interrupt entry and return from interrupt. Fetch and decode are outside the block. The decoder raises one request line together with an instruction-complete strobe. The sequencer then runs a short series of one-clock stack accesses and reports that it is working on `busy_o`.

The stack sits in a single-port synchronous RAM inside the block. Its command bus is registered and brought out on the ports so the pushes can be seen. The stack grows downward, and every push decrements the pointer before it writes. There is one interrupt level and one vector. A request is only honoured at an instruction boundary. A boundary is a completion strobe with no flow request, or the last cycle of a call, return or return-from-interrupt sequence. On entry the block saves the PC and the status word and installs a fresh status word whose enable bit is clear, so a nested interrupt cannot be taken.

Top module: `callret_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, the outputs are `pc_o`=0, `sp_o`=all ones (0xFF), `psw_o`=PSW_RST (0x80, with the enable in bit 7 set), `busy_o`=0 and `mem_we_o`=0.
- R2: A `done_i` pulse with `call_i` first lowers SP by one. The old PC is then written at the new SP, and PC takes `target_i`. In the cycle after the strobe, `mem_we_o`=1, `mem_addr_o`=new SP and `mem_wdata_o`=old PC. `busy_o` is high for one cycle.
- R3: A `done_i` pulse with `ret_i` loads PC from the stack word at SP and then raises SP by one. `busy_o` is high for two cycles.
- R4: An interrupt is taken only at a boundary, and only when `irq_i`, `int_en_i` and PSW bit 7 are all 1. When `done_i` is low and the block is idle, `irq_i` leaves PC and SP unchanged.
- R5: Interrupt entry pushes the PC and then the PSW, with a predecrement before each write. PC then becomes `vector_i`, and PSW becomes `new_psw_i` with bit 7 forced to 0. `busy_o` is high for two cycles.
- R6: A `done_i` pulse with `reti_i` pops the PSW first and the PC second. Each pop reads the word at SP and then raises SP by one. `busy_o` is high for three cycles.
- R7: While `busy_o` is high, `done_i` and the request lines are ignored.
- R8: `busy_o` stays high without a gap from the cycle after the strobe until the last stack access. If a call, return or return-from-interrupt ends while an enabled request is pending, entry follows with no idle cycle, and the busy period is the sum of the two sequences.
- R9: When several requests arrive with one strobe, call wins over return, return wins over return-from-interrupt, and any flow request wins over an interrupt. The interrupt is then taken at the end of that flow request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 1 | Current instruction has completed |
| call_i | input | 1 | Decoded subroutine call |
| ret_i | input | 1 | Decoded subroutine return |
| reti_i | input | 1 | Decoded return from interrupt |
| target_i | input | PC_W | Call target address |
| irq_i | input | 1 | External interrupt request |
| int_en_i | input | 1 | Global interrupt enable |
| vector_i | input | PC_W | Interrupt service entry address |
| new_psw_i | input | PSW_W | Status word installed on entry |
| pc_o | output | PC_W | Program counter |
| sp_o | output | SP_W | Stack pointer |
| psw_o | output | PSW_W | Program status word |
| mem_addr_o | output | SP_W | Stack RAM address (registered) |
| mem_wdata_o | output | DW | Stack RAM write data (registered) |
| mem_we_o | output | 1 | Stack RAM write enable (registered) |
| busy_o | output | 1 | A sequence is in progress |

## Verification
The bench targets the pop order on return from interrupt. A design that popped the PC first would swap the PC and the status word, so the bench checks both values after a round trip. It also covers a call that arrives together with an interrupt request, and a return from interrupt that restores an enabled status while the request is still high. A design that checked for interrupts only on a strobe would miss these entries, and one that dropped `busy_o` between the two sequences would show a short busy count. A request that is raised in the middle of a sequence must leave PC unchanged, which catches a design that accepts strobes while busy. An interrupt held high after entry must not re-enter, which catches a design that failed to clear the enable bit.

// File: rtl/callret_pkg.sv
package callret_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CALL_WR,
    S_RET_RD,
    S_RET_LD,
    S_RTI_RD,
    S_RTI_PSW,
    S_RTI_PC,
    S_INT_PSW,
    S_INT_WR
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CALL,
    OP_RET,
    OP_RETI,
    OP_INT
  } flow_op_e;

endpackage

// File: rtl/callret_ram.sv
module callret_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first single port, one clock of latency
  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/callret_pick.sv
module callret_pick
  import callret_pkg::*;
(
  input  logic     done_i,
  input  logic     call_i,
  input  logic     ret_i,
  input  logic     reti_i,
  input  logic     irq_ok_i,
  output flow_op_e op_o
);
  // flow requests beat the interrupt; it is picked up when they finish
  always_comb begin
    op_o = OP_NONE;
    if (done_i) begin
      if (call_i)        op_o = OP_CALL;
      else if (ret_i)    op_o = OP_RET;
      else if (reti_i)   op_o = OP_RETI;
      else if (irq_ok_i) op_o = OP_INT;
    end
  end
endmodule

// File: rtl/callret_ctl.sv
module callret_ctl
  import callret_pkg::*;
#(
  parameter int             PC_W    = 8,
  parameter int             PSW_W   = 8,
  parameter int             SP_W    = 8,
  parameter int             DW      = 8,
  parameter int             IE_BIT  = 7,
  parameter logic [PSW_W-1:0] PSW_RST = 8'h80
) (
  input  logic             clk,
  input  logic             rst,
  input  flow_op_e         op_i,
  input  logic [PC_W-1:0]  target_i,
  input  logic [PC_W-1:0]  vector_i,
  input  logic [PSW_W-1:0] new_psw_i,
  input  logic             irq_i,
  input  logic             int_en_i,
  input  logic [DW-1:0]    rdata_i,
  output logic             irq_ok_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [SP_W-1:0]  sp_o,
  output logic [PSW_W-1:0] psw_o,
  output logic [SP_W-1:0]  addr_o,
  output logic [DW-1:0]    wdata_o,
  output logic             we_o,
  output logic             busy_o
);
  localparam logic [PSW_W-1:0] IE_MASK = PSW_W'(1) << IE_BIT;

  seq_state_e       state_q, state_n;
  logic [PC_W-1:0]  pc_n, fin_pc;
  logic [SP_W-1:0]  sp_n, fin_sp, addr_n;
  logic [PSW_W-1:0] psw_n;
  logic [DW-1:0]    wdata_n;
  logic             we_n, finish, enter;

  assign irq_ok_o = irq_i & int_en_i & psw_o[IE_BIT];

  always_comb begin
    state_n = state_q;
    pc_n    = pc_o;
    sp_n    = sp_o;
    psw_n   = psw_o;
    addr_n  = addr_o;
    wdata_n = wdata_o;
    we_n    = 1'b0;
    fin_pc  = pc_o;
    fin_sp  = sp_o;
    finish  = 1'b0;
    enter   = 1'b0;
    case (state_q)
      S_IDLE: begin
        case (op_i)
          OP_CALL: begin
            sp_n    = sp_o - 1'b1;
            addr_n  = sp_o - 1'b1;
            wdata_n = DW'(pc_o);
            we_n    = 1'b1;
            pc_n    = target_i;
            state_n = S_CALL_WR;
          end
          OP_RET: begin
            addr_n  = sp_o;
            state_n = S_RET_RD;
          end
          OP_RETI: begin
            addr_n  = sp_o;
            state_n = S_RTI_RD;
          end
          OP_INT:  enter = 1'b1;
          default: ;
        endcase
      end
      S_CALL_WR: finish = 1'b1;
      S_RET_RD:  state_n = S_RET_LD;
      S_RET_LD: begin
        fin_pc = rdata_i[PC_W-1:0];
        fin_sp = sp_o + 1'b1;
        finish = 1'b1;
      end
      S_RTI_RD: begin
        sp_n    = sp_o + 1'b1;
        addr_n  = sp_o + 1'b1;
        state_n = S_RTI_PSW;
      end
      S_RTI_PSW: begin
        psw_n   = rdata_i[PSW_W-1:0];
        state_n = S_RTI_PC;
      end
      S_RTI_PC: begin
        fin_pc = rdata_i[PC_W-1:0];
        fin_sp = sp_o + 1'b1;
        finish = 1'b1;
      end
      S_INT_PSW: begin
        sp_n    = sp_o - 1'b1;
        addr_n  = sp_o - 1'b1;
        wdata_n = DW'(psw_o);
        we_n    = 1'b1;
        psw_n   = new_psw_i & ~IE_MASK;
        state_n = S_INT_WR;
      end
      S_INT_WR:  state_n = S_IDLE;
      default:   state_n = S_IDLE;
    endcase

    // end of a flow sequence is an instruction boundary
    if (finish) begin
      if (irq_ok_o) begin
        enter = 1'b1;
      end else begin
        pc_n    = fin_pc;
        sp_n    = fin_sp;
        state_n = S_IDLE;
      end
    end

    if (enter) begin
      sp_n    = fin_sp - 1'b1;
      addr_n  = fin_sp - 1'b1;
      wdata_n = DW'(fin_pc);
      we_n    = 1'b1;
      pc_n    = vector_i;
      state_n = S_INT_PSW;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      pc_o    <= '0;
      sp_o    <= '1;
      psw_o   <= PSW_RST;
      addr_o  <= '0;
      wdata_o <= '0;
      we_o    <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      state_q <= state_n;
      pc_o    <= pc_n;
      sp_o    <= sp_n;
      psw_o   <= psw_n;
      addr_o  <= addr_n;
      wdata_o <= wdata_n;
      we_o    <= we_n;
      busy_o  <= (state_n != S_IDLE);
    end
  end
endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
#(
  parameter int               PC_W    = 8,
  parameter int               PSW_W   = 8,
  parameter int               SP_W    = 8,
  parameter int               IE_BIT  = 7,
  parameter logic [PSW_W-1:0] PSW_RST = 8'h80,
  localparam int              DW      = (PC_W > PSW_W) ? PC_W : PSW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_i,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             reti_i,
  input  logic [PC_W-1:0]  target_i,
  input  logic             irq_i,
  input  logic             int_en_i,
  input  logic [PC_W-1:0]  vector_i,
  input  logic [PSW_W-1:0] new_psw_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [SP_W-1:0]  sp_o,
  output logic [PSW_W-1:0] psw_o,
  output logic [SP_W-1:0]  mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic             mem_we_o,
  output logic             busy_o
);
  flow_op_e      op;
  logic          irq_ok;
  logic [DW-1:0] rdata;

  callret_pick pick_i (
    .done_i   (done_i & ~busy_o),
    .call_i   (call_i),
    .ret_i    (ret_i),
    .reti_i   (reti_i),
    .irq_ok_i (irq_ok),
    .op_o     (op)
  );

  callret_ctl #(
    .PC_W(PC_W), .PSW_W(PSW_W), .SP_W(SP_W), .DW(DW),
    .IE_BIT(IE_BIT), .PSW_RST(PSW_RST)
  ) ctl_i (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op),
    .target_i  (target_i),
    .vector_i  (vector_i),
    .new_psw_i (new_psw_i),
    .irq_i     (irq_i),
    .int_en_i  (int_en_i),
    .rdata_i   (rdata),
    .irq_ok_o  (irq_ok),
    .pc_o      (pc_o),
    .sp_o      (sp_o),
    .psw_o     (psw_o),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_wdata_o),
    .we_o      (mem_we_o),
    .busy_o    (busy_o)
  );

  callret_ram #(.AW(SP_W), .DW(DW)) ram_i (
    .clk     (clk),
    .we_i    (mem_we_o),
    .addr_i  (mem_addr_o),
    .wdata_i (mem_wdata_o),
    .rdata_o (rdata)
  );
endmodule

// File: rtl/callret_chk.sv
module callret_chk #(
  parameter int PC_W   = 8,
  parameter int PSW_W  = 8,
  parameter int SP_W   = 8,
  parameter int DW     = 8,
  parameter int IE_BIT = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             done_i,
  input logic             call_i,
  input logic [PC_W-1:0]  target_i,
  input logic [PC_W-1:0]  pc_o,
  input logic [SP_W-1:0]  sp_o,
  input logic [PSW_W-1:0] psw_o,
  input logic [SP_W-1:0]  mem_addr_o,
  input logic [DW-1:0]    mem_wdata_o,
  input logic             mem_we_o,
  input logic             busy_o
);
  assert_call_push_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && done_i && call_i) |=>
      (mem_we_o && mem_addr_o == $past(sp_o) - 1'b1 && sp_o == $past(sp_o) - 1'b1
       && mem_wdata_o == DW'($past(pc_o)) && pc_o == $past(target_i)));

  assert_sp_step_R3: assert property (@(posedge clk) disable iff (rst)
    (sp_o == $past(sp_o)) || (sp_o == $past(sp_o) + 1'b1) || (sp_o == $past(sp_o) - 1'b1));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !done_i) |=> ($stable(pc_o) && $stable(sp_o) && !busy_o));

  assert_entry_mask_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_we_o) && $past(mem_we_o, 2)) |-> !psw_o[IE_BIT]);

  assert_we_busy_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> busy_o);
endmodule

bind callret_seq callret_chk #(
  .PC_W(PC_W), .PSW_W(PSW_W), .SP_W(SP_W), .DW(DW), .IE_BIT(IE_BIT)
) chk_i (
  .clk(clk), .rst(rst), .done_i(done_i), .call_i(call_i), .target_i(target_i),
  .pc_o(pc_o), .sp_o(sp_o), .psw_o(psw_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o), .busy_o(busy_o)
);

// File: tb/callret_seq_tb_top.sv
module callret_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       done = 1'b0, call = 1'b0, ret = 1'b0, reti = 1'b0;
  logic [7:0] tgt = '0;
  logic       irq = 1'b0, int_en = 1'b1;
  logic [7:0] vec = 8'h40;
  logic [7:0] npsw = 8'h85;
  logic [7:0] pc, sp, psw, maddr, mwd;
  logic       mwe, busy;

  int tests = 0, fails = 0;
  logic [7:0] f_addr, f_wd;
  logic       f_we;
  int         bcnt;

  always #5 clk = ~clk;

  callret_seq dut_i (
    .clk(clk), .rst(rst), .done_i(done), .call_i(call), .ret_i(ret), .reti_i(reti),
    .target_i(tgt), .irq_i(irq), .int_en_i(int_en), .vector_i(vec), .new_psw_i(npsw),
    .pc_o(pc), .sp_o(sp), .psw_o(psw), .mem_addr_o(maddr), .mem_wdata_o(mwd),
    .mem_we_o(mwe), .busy_o(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // op: 0 call, 1 ret, 2 reti, 3 interrupt only, 4 strobe only
  task automatic do_op(input int op, input logic [7:0] t, input bit hold_irq, input bit inject);
    @(negedge clk);
    done = 1'b1; call = (op == 0); ret = (op == 1); reti = (op == 2); tgt = t;
    if (op == 3 || hold_irq) irq = 1'b1;
    @(negedge clk);
    done = 1'b0; call = 1'b0; ret = 1'b0; reti = 1'b0;
    if (!hold_irq) irq = 1'b0;
    f_we = mwe; f_addr = maddr; f_wd = mwd;
    bcnt = 0;
    while (busy && bcnt < 40) begin
      bcnt++;
      if (inject && bcnt == 1) begin done = 1'b1; call = 1'b1; tgt = 8'h77; end
      else begin done = 1'b0; call = 1'b0; end
      @(negedge clk);
    end
    done = 1'b0; call = 1'b0;
  endtask

  // {op[1:0], target, exp pc, exp sp, exp psw}
  localparam logic [33:0] TBL [8] = '{
    {2'd0, 8'h10, 8'h10, 8'hFE, 8'h80},
    {2'd0, 8'h20, 8'h20, 8'hFD, 8'h80},
    {2'd1, 8'h00, 8'h10, 8'hFE, 8'h80},
    {2'd3, 8'h00, 8'h40, 8'hFC, 8'h05},
    {2'd0, 8'h50, 8'h50, 8'hFB, 8'h05},
    {2'd1, 8'h00, 8'h40, 8'hFC, 8'h05},
    {2'd2, 8'h00, 8'h10, 8'hFE, 8'h80},
    {2'd1, 8'h00, 8'h00, 8'hFF, 8'h80}
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pc", pc, 0); check("R1 sp", sp, 8'hFF); check("R1 psw", psw, 8'h80);
    check("R1 busy", busy, 0); check("R1 we", mwe, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sp after release", sp, 8'hFF);

    // R2 R3 R5 R6: vector walk
    for (int i = 0; i < 8; i++) begin
      do_op(int'(TBL[i][33:32]), TBL[i][31:24], 1'b0, 1'b0);
      check("R2/R3/R5/R6 pc", pc, TBL[i][23:16]);
      check("R2/R3/R5/R6 sp", sp, TBL[i][15:8]);
      check("R5/R6 psw", psw, TBL[i][7:0]);
    end

    // R4: request with no boundary
    irq = 1'b1;
    repeat (5) @(negedge clk);
    check("R4 pc no boundary", pc, 0); check("R4 busy no boundary", busy, 0);
    irq = 1'b0;
    // R4: global enable low
    int_en = 1'b0;
    do_op(3, 8'h00, 1'b0, 1'b0);
    check("R4 masked pc", pc, 0); check("R4 masked sp", sp, 8'hFF);
    int_en = 1'b1;

    // R2 R8 R9: call and interrupt on one strobe
    do_op(0, 8'h33, 1'b1, 1'b0);
    check("R2 push we", f_we, 1); check("R2 push addr", f_addr, 8'hFE); check("R2 push data", f_wd, 8'h00);
    check("R8 chained busy", bcnt, 3);
    check("R9 pc", pc, 8'h40); check("R9 sp", sp, 8'hFC); check("R5 psw", psw, 8'h05);

    // R5: enable cleared, held request does not nest
    do_op(4, 8'h00, 1'b1, 1'b0);
    check("R5 no nest pc", pc, 8'h40); check("R5 no nest sp", sp, 8'hFC);

    // R6 R8: return from interrupt re-enters at once
    do_op(2, 8'h00, 1'b1, 1'b0);
    check("R8 reenter busy", bcnt, 5);
    check("R8 reenter pc", pc, 8'h40); check("R8 reenter sp", sp, 8'hFC); check("R8 reenter psw", psw, 8'h05);
    irq = 1'b0;

    // R6 R7: return from interrupt with a strobe injected while busy
    do_op(2, 8'h00, 1'b0, 1'b1);
    check("R6 busy", bcnt, 3);
    check("R7 pc", pc, 8'h33); check("R7 sp", sp, 8'hFE); check("R6 psw", psw, 8'h80);
    do_op(1, 8'h00, 1'b0, 1'b0);
    check("R3 busy", bcnt, 2);
    check("R3 pc", pc, 8'h00); check("R3 sp", sp, 8'hFF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule